// File: doc/BRIEF.md
# Ping-Pong Memory TDMA Serial Multiplexer

This block merges four serial channels into one time-division stream. All channels share a slow input bit clock. Every 64 input clocks, each channel delivers one 64-bit sample. The block sends those samples on a single serial line driven by a fast clock that runs at exactly four times the input rate and is phase-aligned with it. Each output frame has four equal slots: channel 1's sample, then channel 2's, then channel 3's, then channel 4's. Within each slot the bits leave in the order they arrived.

The transposition happens in an inferred dual-port memory of 2 × 64 words, each 4 bits wide. Each word holds one bit lane per channel. The write side fills one 64-word half with the frame now arriving. The read side sweeps the other half, which holds the previous frame, four times in one frame period and picks a different lane on each sweep. The halves swap at every frame boundary. The boundary event is carried into the fast domain through a two-flop synchronizer. The output carries a valid flag, which stays low until the first full frame has been stored.

Top module: `tdma_pingpong_mux`

## Requirements
- R1: On each rising edge of the input clock after reset, the four input bits are stored as one word at the current write address of the write half. Bit i of the word (bit 0 to bit 3) holds channel i+1.
- R2: On each falling edge of the input clock after the first rising edge, the write address advances by one and wraps from 63 to 0. The write half inverts exactly on that wrap.
- R3: On each falling edge of the fast clock, the read address advances by one and wraps from 63 to 0. The slot counter (0 to 3) advances on that wrap. The sample length and the channel count are powers of two.
- R4: A change of the write half reaches the read domain through two flops. On the resulting frame pulse, the read address and the slot counter restart at 0, and the read half becomes the half that was just completed.
- R5: On each rising edge of the fast clock, the word at the read address is fetched. The serial output then shows the bit of lane `slot` of that word.
- R6: Each 256-bit output frame is channel 1's sample, then channel 2's, then channel 3's, then channel 4's. Each sample is sent with its first-received bit first.
- R7: `valid_o` stays low until the first complete frame has been stored and then stays high. While it is low, `serial_o` is 0.
- R8: Consecutive frames come out back to back with no gap. Each frame appears one frame period after it was received.
- R9: An asynchronous low on `rst_ni` clears the address counters, the halves, the slot counter and `valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in_i | input | 1 | Input bit clock, shared by all channels |
| clk_fast_i | input | 1 | Output bit clock, 4× clk_in_i and phase-aligned |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 4 | One input bit per channel; bit 0 is channel 1 |
| serial_o | output | 1 | Multiplexed TDMA serial stream |
| valid_o | output | 1 | High once the stream carries stored frames |

## Verification
On every cycle, assertions check the following:
- the write address steps by one, and the write half inverts only at the 63-to-0 wrap;
- the read address steps by one, and the slot counter advances only on its wrap;
- each frame pulse restarts the sweep on the half opposite to the one now being filled;
- `valid_o` never falls once it has risen;
- the output lane changes only by +1.

Only the bench scenarios can show that the right bits arrive in the right slot and order. The bench compares whole 64-bit samples per channel across several frames, including all-zero, all-one and single-bit patterns. It also measures how long `valid_o` stays low after reset.

// File: rtl/tdma_mux_pkg.sv
package tdma_mux_pkg;
  localparam int unsigned DefChannels   = 4;
  localparam int unsigned DefSampleBits = 64;
endpackage

// File: rtl/tdma_dpram.sv
module tdma_dpram #(
  parameter int unsigned DATA_W = 4,
  parameter int unsigned ADDR_W = 7
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rclk_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned Depth = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [Depth];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i) begin
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/tdma_wr_ctrl.sv
module tdma_wr_ctrl #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] addr_o,
  output logic              half_o
);
  logic              armed_q;
  logic [ADDR_W-1:0] addr_q;
  logic              half_q;

  // blocks a falling edge that precedes the first write after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      half_q <= 1'b0;
    end else if (armed_q) begin
      addr_q <= addr_q + 1'b1;
      if (addr_q == '1) half_q <= ~half_q;
    end
  end

  assign addr_o = addr_q;
  assign half_o = half_q;

  p_addr_step_r2: assert property (@(negedge clk_i) disable iff (!rst_ni)
    armed_q |=> addr_q == $past(addr_q) + 1'b1);
  p_half_flip_r2: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (armed_q && addr_q == '1) |=> half_q != $past(half_q));
  p_half_hold_r2: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (armed_q && addr_q != '1) |=> $stable(half_q));
endmodule

// File: rtl/tdma_rd_ctrl.sv
module tdma_rd_ctrl #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned SLOT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_half_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              half_o,
  output logic              valid_o
);
  logic [2:0]        sync_q;
  logic              frame_pulse;
  logic [ADDR_W-1:0] addr_q;
  logic [SLOT_W-1:0] slot_q;
  logic              half_q;
  logic              valid_q;

  // [0],[1]: synchronizer; [2]: history for edge detect
  assign frame_pulse = sync_q[1] ^ sync_q[2];

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      addr_q  <= '0;
      slot_q  <= '0;
      half_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], wr_half_i};
      if (frame_pulse) begin
        addr_q  <= '0;
        slot_q  <= '0;
        half_q  <= sync_q[2];
        valid_q <= 1'b1;
      end else begin
        addr_q <= addr_q + 1'b1;
        if (addr_q == '1) slot_q <= slot_q + 1'b1;
      end
    end
  end

  assign addr_o  = addr_q;
  assign slot_o  = slot_q;
  assign half_o  = half_q;
  assign valid_o = valid_q;

  p_addr_step_r3: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !frame_pulse |=> addr_q == $past(addr_q) + 1'b1);
  p_slot_wrap_r3: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!frame_pulse && addr_q == '1) |=> slot_q == $past(slot_q) + 1'b1);
  p_restart_r4: assert property (@(negedge clk_i) disable iff (!rst_ni)
    frame_pulse |=> (addr_q == '0 && slot_q == '0 && half_q != sync_q[2]));
  p_valid_sticky_r7: assert property (@(negedge clk_i) disable iff (!rst_ni)
    valid_q |=> valid_q);
endmodule

// File: rtl/tdma_pingpong_mux.sv
module tdma_pingpong_mux
  import tdma_mux_pkg::*;
#(
  parameter int unsigned NUM_CH      = DefChannels,
  parameter int unsigned SAMPLE_BITS = DefSampleBits
) (
  input  logic              clk_in_i,
  input  logic              clk_fast_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] data_i,
  output logic              serial_o,
  output logic              valid_o
);
  localparam int unsigned AddrW = $clog2(SAMPLE_BITS);
  localparam int unsigned SlotW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int unsigned MemAw = AddrW + 1;

  logic [AddrW-1:0]  wr_addr, rd_addr;
  logic              wr_half, rd_half, rd_valid;
  logic [SlotW-1:0]  rd_slot;
  logic [NUM_CH-1:0] rd_word;
  logic [SlotW-1:0]  lane_q;
  logic              vld_q;

  tdma_wr_ctrl #(.ADDR_W(AddrW)) u_wr (
    .clk_i (clk_in_i),
    .rst_ni(rst_ni),
    .addr_o(wr_addr),
    .half_o(wr_half)
  );

  tdma_rd_ctrl #(.ADDR_W(AddrW), .SLOT_W(SlotW)) u_rd (
    .clk_i    (clk_fast_i),
    .rst_ni   (rst_ni),
    .wr_half_i(wr_half),
    .addr_o   (rd_addr),
    .slot_o   (rd_slot),
    .half_o   (rd_half),
    .valid_o  (rd_valid)
  );

  tdma_dpram #(.DATA_W(NUM_CH), .ADDR_W(MemAw)) u_mem (
    .wclk_i (clk_in_i),
    .we_i   (rst_ni),
    .waddr_i({wr_half, wr_addr}),
    .wdata_i(data_i),
    .rclk_i (clk_fast_i),
    .raddr_i({rd_half, rd_addr}),
    .rdata_o(rd_word)
  );

  // lane and valid captured with the word so all three stay aligned
  always_ff @(posedge clk_fast_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      lane_q <= rd_slot;
      vld_q  <= rd_valid;
    end
  end

  assign serial_o = vld_q & rd_word[lane_q];
  assign valid_o  = vld_q;

  p_lane_order_r6: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
    (vld_q && $past(vld_q) && lane_q != $past(lane_q))
      |-> lane_q == $past(lane_q) + 1'b1);
endmodule

// File: tb/tb_tdma_pingpong_mux.sv
module tb_tdma_pingpong_mux;
  localparam int NCH = 4;
  localparam int SW  = 64;
  localparam int NF  = 8;

  logic           clk_in, clk_fast, rst_ni;
  logic [NCH-1:0] data_i;
  logic           serial_o, valid_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [SW-1:0] samp [NF+1][NCH];

  tdma_pingpong_mux #(.NUM_CH(NCH), .SAMPLE_BITS(SW)) dut (
    .clk_in_i  (clk_in),
    .clk_fast_i(clk_fast),
    .rst_ni    (rst_ni),
    .data_i    (data_i),
    .serial_o  (serial_o),
    .valid_o   (valid_o)
  );

  // 125 MHz fast clock; input clock is /4, rising edges aligned
  initial begin
    clk_fast = 1'b0;
    #4;
    forever begin clk_fast = 1'b1; #4; clk_fast = 1'b0; #4; end
  end
  initial begin
    clk_in = 1'b0;
    #4;
    forever begin clk_in = 1'b1; #16; clk_in = 1'b0; #16; end
  end

  task automatic check(input bit ok, input string req, input logic [SW-1:0] act,
                       input logic [SW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int f = 0; f <= NF; f++) begin
      for (int c = 0; c < NCH; c++) begin
        if (f == 0)      samp[f][c] = {16{4'(c + 1)}};
        else if (f == 1) samp[f][c] = '0;
        else if (f == 2) samp[f][c] = '1;
        else if (f == 3) samp[f][c] = 64'h1 << (c * 16 + 3);
        else if (f == NF) samp[f][c] = '0;
        else samp[f][c] = {32'(f * 32'h9E3779B9 ^ c * 32'h85EBCA6B),
                           32'(c * 32'h27D4EB2F + f * 7)};
      end
    end
  end

  // driver
  initial begin
    rst_ni = 1'b0;
    data_i = '0;
    #50;
    // R9: outputs cleared under reset
    check(valid_o == 1'b0, "R9 valid in reset", 64'(valid_o), 64'h0);
    check(serial_o == 1'b0, "R9 serial in reset", 64'(serial_o), 64'h0);
    #40;
    rst_ni = 1'b1;
    for (int f = 0; f <= NF; f++) begin
      for (int b = 0; b < SW; b++) begin
        for (int c = 0; c < NCH; c++) data_i[c] = samp[f][c][SW-1-b];
        @(negedge clk_in);
      end
    end
  end

  // collector
  initial begin
    int low_cnt;
    bit zero_ok;
    logic [SW-1:0] got;
    bit vld_ok;
    low_cnt = 0;
    zero_ok = 1;
    wait (rst_ni == 1'b1);
    @(negedge clk_fast);
    while (!valid_o && low_cnt < 400) begin
      if (serial_o) zero_ok = 0;
      low_cnt++;
      @(negedge clk_fast);
    end
    // R7: low for the whole first frame (256 fast bits) plus sync latency
    check(low_cnt >= 256 && low_cnt <= 260, "R7 valid low during first frame",
          64'(low_cnt), 64'd258);
    check(zero_ok, "R7 serial zero while invalid", 64'(!zero_ok), 64'h0);
    for (int f = 0; f < NF; f++) begin
      vld_ok = 1;
      for (int c = 0; c < NCH; c++) begin
        got = '0;
        for (int b = 0; b < SW; b++) begin
          if (!valid_o) vld_ok = 0;
          got = {got[SW-2:0], serial_o};
          @(negedge clk_fast);
        end
        // R1 R5 R6: slot c holds channel c+1, first-received bit first
        check(got == samp[f][c], $sformatf("R6 frame %0d channel %0d", f, c + 1),
              got, samp[f][c]);
      end
      // R8: frames back to back with valid held high
      check(vld_ok, $sformatf("R8 valid held across frame %0d", f),
            64'(!vld_ok), 64'h0);
    end
    finish_run();
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk_fast);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule